// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Master

This block loads an SRAM-based FPGA through its passive serial pins. A one-cycle start strobe begins a load. The block drives the target's active-low configuration request low for a fixed hold time. It then confirms that the target's active-low status line answers low, releases the request, and waits, with a time limit, for status to go high. Once the handshake has passed, the block accepts the configuration image as a byte stream. It shifts every byte out least significant bit first on a serial data pin, together with a serial clock that the target samples on its rising edge.

The byte stream uses valid/ready. `in_ready_o` is high only while the block waits for the next byte, with the serial clock parked low. A byte moves on a rising system clock edge where `in_valid_i` and `in_ready_o` are both high. Holding `in_valid_i` low stalls the load for any number of cycles with the clock parked low, which the target tolerates. `in_last_i` marks the final byte of the image.

After the final byte and one further low phase, the block samples the target's done input. If it is high, the block issues a fixed burst of extra clock pulses and reports success. Any failed check aborts the load and leaves a 2-bit error code. All timing is given in system clock cycles: the half-period of the serial clock, the request hold time and the status timeout. With a 50 MHz system clock and a phase length of 1, the serial clock runs at 25 MHz, which is under the 50 MHz limit.

Top module: `pscfg_master`

## Requirements
- R1: After a start strobe in idle, `cfg_req_n_o` goes low on the next edge and stays low for exactly CFG_LOW_CYC system cycles.
- R2: If `tgt_stat_n_i` is high in the last cycle of the request hold, the load aborts with error code 1 and no serial clock pulse is issued.
- R3: After the request is released, if `tgt_stat_n_i` has not gone high within STATUS_TMO_CYC cycles, the load aborts with error code 2, exactly STATUS_TMO_CYC cycles after the release.
- R4: Each accepted byte produces exactly 8 serial clock rising edges, and the data seen at those edges is bit 0 first and bit 7 last.
- R5: Every serial clock high phase lasts exactly PHASE_CYC cycles, and every low phase before a rising edge lasts at least PHASE_CYC cycles. `sdata_o` changes only while the clock is low.
- R6: If `tgt_done_i` is low when it is sampled after the final byte, the load aborts with error code 3 and no extra pulses are issued.
- R7: If `tgt_done_i` is high at that point, exactly TAIL_PULSES (12) extra high-then-low pulses follow. Then `done_o` goes high with error code 0 and `busy_o` falls.
- R8: `in_ready_o` is high only while the block waits for a byte: request high and serial clock low. A byte is taken only when valid and ready are both high, and gaps in valid do not change the bit stream.
- R9: On an abort, request goes high, the clock parks low, ready is low and `busy_o` is low. The error code holds until the next start, which clears it, and a following good load reports code 0.
- R10: A start strobe while `busy_o` is high has no effect: the request does not fall again and the bit stream is unchanged.
- R11: After reset, the request is high, the clock is low, and busy, done, ready and the error code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, acted on only when idle |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_last_i | input | 1 | Marks the final byte of the image |
| in_ready_o | output | 1 | Block can take a byte |
| cfg_req_n_o | output | 1 | Active-low configuration request to target |
| sclk_o | output | 1 | Serial configuration clock |
| sdata_o | output | 1 | Serial configuration data |
| tgt_stat_n_i | input | 1 | Target active-low status |
| tgt_done_i | input | 1 | Target configuration-done |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Last load succeeded |
| err_o | output | 2 | 0 none, 1 status not asserted, 2 status release timeout, 3 done not asserted |

## Verification
The bench streams all 256 byte values in one image and rebuilds each byte from the data seen at the serial clock's rising edges. A design that shifted MSB first, or dropped or repeated a bit at a byte boundary, would corrupt the rebuilt bytes or the count of rising edges. It measures the exact length of the request hold, of every clock high phase and of the status timeout. An off-by-one timer therefore shows up as a wrong count, not as a hang. It drives a target whose status never asserts, one whose status never releases and one whose done stays low, and it counts the tail pulses, which exposes a design that clocks the tail without checking done or issues eleven or thirteen pulses. It also sends stall gaps and a start strobe in the middle of a load, which a design that restarts or takes a byte without ready would not survive.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_REQ_HOLD,
    SQ_REL_WAIT,
    SQ_FETCH,
    SQ_BIT_LO,
    SQ_BIT_HI,
    SQ_DONE_CHK,
    SQ_TAIL_HI,
    SQ_TAIL_LO
  } seq_state_e;

  typedef enum logic [1:0] {
    FAIL_NONE     = 2'd0,
    FAIL_NO_STAT  = 2'd1,
    FAIL_STAT_TMO = 2'd2,
    FAIL_NO_DONE  = 2'd3
  } fail_code_e;

endpackage

// File: rtl/pscfg_timer.sv
module pscfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= value_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pscfg_shifter.sv
module pscfg_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] byte_i,
  input  logic          shift_i,
  output logic          bit_o,
  output logic          final_bit_o
);

  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sr_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= byte_i;
      left_q <= CW'(DW);
    end else if (shift_i) begin
      sr_q   <= sr_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o       = sr_q[0];
  assign final_bit_o = (left_q == CW'(1));

  // R4: a shift is only requested while bits of the byte remain
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (left_q > CW'(1)));

endmodule

// File: rtl/pscfg_master.sv
module pscfg_master
  import pscfg_pkg::*;
#(
  parameter int PHASE_CYC      = 1,
  parameter int CFG_LOW_CYC    = 110,
  parameter int STATUS_TMO_CYC = 5_000_000,
  parameter int TAIL_PULSES    = 12,
  parameter int DW             = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_last_i,
  output logic          in_ready_o,
  output logic          cfg_req_n_o,
  output logic          sclk_o,
  output logic          sdata_o,
  input  logic          tgt_stat_n_i,
  input  logic          tgt_done_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    err_o
);

  localparam int MAXC = (STATUS_TMO_CYC > CFG_LOW_CYC) ?
                        ((STATUS_TMO_CYC > PHASE_CYC) ? STATUS_TMO_CYC : PHASE_CYC) :
                        ((CFG_LOW_CYC > PHASE_CYC) ? CFG_LOW_CYC : PHASE_CYC);
  localparam int TW = $clog2(MAXC + 1);
  localparam int PW = $clog2(TAIL_PULSES + 1);
  localparam logic [TW-1:0] PH_LD  = TW'(PHASE_CYC - 1);
  localparam logic [TW-1:0] REQ_LD = TW'(CFG_LOW_CYC - 1);
  localparam logic [TW-1:0] TMO_LD = TW'(STATUS_TMO_CYC - 1);

  seq_state_e st_q, st_d;
  logic       req_n_q, req_n_d;
  logic       sclk_q, sclk_d;
  logic       done_q, done_d;
  fail_code_e err_q, err_d;
  logic       last_q;
  logic [PW-1:0] tail_q;
  logic       tail_clr, tail_inc;

  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          sh_load, sh_shift, sh_bit, sh_final;

  pscfg_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(t_load), .value_i(t_val), .zero_o(t_zero)
  );

  pscfg_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(sh_load), .byte_i(in_data_i),
    .shift_i(sh_shift), .bit_o(sh_bit), .final_bit_o(sh_final)
  );

  always_comb begin
    st_d     = st_q;
    req_n_d  = req_n_q;
    sclk_d   = sclk_q;
    done_d   = done_q;
    err_d    = err_q;
    t_load   = 1'b0;
    t_val    = PH_LD;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    tail_clr = 1'b0;
    tail_inc = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start_i) begin
        st_d    = SQ_REQ_HOLD;
        req_n_d = 1'b0;
        done_d  = 1'b0;
        err_d   = FAIL_NONE;
        t_load  = 1'b1;
        t_val   = REQ_LD;
      end
      SQ_REQ_HOLD: if (t_zero) begin
        req_n_d = 1'b1;
        if (tgt_stat_n_i) begin
          st_d  = SQ_IDLE;
          err_d = FAIL_NO_STAT;
        end else begin
          st_d   = SQ_REL_WAIT;
          t_load = 1'b1;
          t_val  = TMO_LD;
        end
      end
      SQ_REL_WAIT: begin
        if (tgt_stat_n_i) st_d = SQ_FETCH;
        else if (t_zero) begin
          st_d  = SQ_IDLE;
          err_d = FAIL_STAT_TMO;
        end
      end
      SQ_FETCH: if (in_valid_i) begin
        sh_load = 1'b1;
        st_d    = SQ_BIT_LO;
        t_load  = 1'b1;
      end
      SQ_BIT_LO: if (t_zero) begin
        sclk_d = 1'b1;
        st_d   = SQ_BIT_HI;
        t_load = 1'b1;
      end
      SQ_BIT_HI: if (t_zero) begin
        sclk_d = 1'b0;
        if (!sh_final) begin
          sh_shift = 1'b1;
          st_d     = SQ_BIT_LO;
          t_load   = 1'b1;
        end else if (last_q) begin
          st_d   = SQ_DONE_CHK;
          t_load = 1'b1;
        end else begin
          st_d = SQ_FETCH;
        end
      end
      SQ_DONE_CHK: if (t_zero) begin
        if (tgt_done_i) begin
          st_d     = SQ_TAIL_HI;
          sclk_d   = 1'b1;
          t_load   = 1'b1;
          tail_clr = 1'b1;
        end else begin
          st_d  = SQ_IDLE;
          err_d = FAIL_NO_DONE;
        end
      end
      SQ_TAIL_HI: if (t_zero) begin
        sclk_d = 1'b0;
        st_d   = SQ_TAIL_LO;
        t_load = 1'b1;
      end
      SQ_TAIL_LO: if (t_zero) begin
        if (tail_q == PW'(TAIL_PULSES - 1)) begin
          st_d   = SQ_IDLE;
          done_d = 1'b1;
        end else begin
          tail_inc = 1'b1;
          sclk_d   = 1'b1;
          st_d     = SQ_TAIL_HI;
          t_load   = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      req_n_q <= 1'b1;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= FAIL_NONE;
      last_q  <= 1'b0;
      tail_q  <= '0;
    end else begin
      st_q    <= st_d;
      req_n_q <= req_n_d;
      sclk_q  <= sclk_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (sh_load)       last_q <= in_last_i;
      if (tail_clr)      tail_q <= '0;
      else if (tail_inc) tail_q <= tail_q + 1'b1;
    end
  end

  assign in_ready_o  = (st_q == SQ_FETCH);
  assign cfg_req_n_o = req_n_q;
  assign sclk_o      = sclk_q;
  assign sdata_o     = sh_bit;
  assign busy_o      = (st_q != SQ_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R8: ready only with the request released and the clock parked low
  a_r8_ready_parked: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> (cfg_req_n_o && !sclk_o));

  // R5: data holds through every clock high phase
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  // R9: an error leaves the pins parked and the block idle
  a_r9_abort_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != 2'd0) |-> (cfg_req_n_o && !sclk_o && !in_ready_o && !busy_o));

  // R10: the request only falls out of idle
  a_r10_req_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_req_n_o) |-> !$past(busy_o));

  // R7: success is reported only with the block idle and no error
  a_r7_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && err_o == 2'd0));

endmodule

// File: tb/sim_pscfg_master.sv
module sim_pscfg_master;

  localparam int PH   = 2;
  localparam int REQ  = 5;
  localparam int TMO  = 20;
  localparam int TAIL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_last = 1'b0;
  logic in_ready, cfg_n, sclk, sdata, busy, done;
  logic [1:0] err;
  logic stat_n = 1'b1;
  logic tgt_done = 1'b1;

  always #10 clk = ~clk;

  pscfg_master #(
    .PHASE_CYC(PH), .CFG_LOW_CYC(REQ), .STATUS_TMO_CYC(TMO), .TAIL_PULSES(TAIL), .DW(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .cfg_req_n_o(cfg_n), .sclk_o(sclk), .sdata_o(sdata),
    .tgt_stat_n_i(stat_n), .tgt_done_i(tgt_done),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0;
  int fails = 0;

  // target status model: 0 normal, 1 never asserts, 2 never releases
  int stat_mode = 0;
  int rel_cnt = 0;
  always @(negedge clk) begin
    if (!cfg_n) begin
      stat_n  <= (stat_mode == 1);
      rel_cnt <= 0;
    end else if (stat_mode == 2) begin
      stat_n <= 1'b0;
    end else if (rel_cnt < 3) begin
      rel_cnt <= rel_cnt + 1;
    end else begin
      stat_n <= 1'b1;
    end
  end

  // pin monitor
  logic mon_clr = 1'b0;
  logic [7:0] cap [0:299];
  int cap_n, hi_run, lo_run, hi_bad, lo_short, chg_hi, rdy_bad, cfg_falls, cfg_low;
  logic p_sclk, p_sdata, p_cfg;
  always @(negedge clk) begin
    if (mon_clr) begin
      cap_n = 0; hi_run = 0; lo_run = 0; hi_bad = 0; lo_short = 0;
      chg_hi = 0; rdy_bad = 0; cfg_falls = 0; cfg_low = 0;
    end else begin
      if (sclk && !p_sclk) begin
        cap[cap_n / 8][cap_n % 8] = sdata;
        cap_n++;
        if (lo_run < PH) lo_short++;
      end
      if (sclk) hi_run++;
      if (!sclk && p_sclk) begin
        if (hi_run != PH) hi_bad++;
        hi_run = 0;
        lo_run = 0;
      end
      if (!sclk) lo_run++;
      if (sclk && p_sclk && sdata != p_sdata) chg_hi++;
      if (in_ready && (sclk || !cfg_n)) rdy_bad++;
      if (!cfg_n && p_cfg) begin cfg_falls++; cfg_low = 0; end
      if (!cfg_n) cfg_low++;
    end
    p_sclk = sclk; p_sdata = sdata; p_cfg = cfg_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [7:0] sent [0:299];

  task automatic clear_mon();
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 30000; k++) begin
      if (!busy) return;
      @(negedge clk);
    end
    chk("idle wait", 0, 1);
  endtask

  task automatic run_load(input int n, input int gap_mod, input bit mid_start);
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_data  = sent[i];
      in_last  = (i == n - 1);
      in_valid = 1'b1;
      while (!in_ready && busy) @(negedge clk);
      if (!busy) begin
        in_valid = 1'b0;
        return;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (mid_start && i == 3) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      if (gap_mod > 0) repeat (i % gap_mod) @(negedge clk);
    end
    wait_idle();
  endtask

  function automatic int bytes_ok(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] != sent[i]) bad++;
    return bad;
  endfunction

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 req", cfg_n, 1);
    chk("R11 sclk", sclk, 0);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 ready", in_ready, 0);
    chk("R11 err", err, 0);

    // exhaustive byte sweep: R1 R4 R5 R7 R8
    for (int i = 0; i < 256; i++) sent[i] = 8'(i);
    run_load(256, 0, 1'b0);
    chk("R1 request low cycles", cfg_low, REQ);
    chk("R4 rising edges", cap_n, 256 * 8 + TAIL);
    chk("R4 byte mismatches LSB first", bytes_ok(256), 0);
    chk("R5 high phase width errors", hi_bad, 0);
    chk("R5 short low phases", lo_short, 0);
    chk("R5 data change while high", chg_hi, 0);
    chk("R8 ready while not parked", rdy_bad, 0);
    chk("R7 done", done, 1);
    chk("R7 err", err, 0);
    chk("R7 busy", busy, 0);

    // gapped stream with a start strobe mid-load: R8 R10
    for (int i = 0; i < 16; i++) sent[i] = 8'((i * 37 + 5) & 255);
    run_load(16, 3, 1'b1);
    chk("R10 request falls", cfg_falls, 1);
    chk("R10 rising edges", cap_n, 16 * 8 + TAIL);
    chk("R8 gapped bytes", bytes_ok(16), 0);
    chk("R8 ready while not parked", rdy_bad, 0);
    chk("R7 done gapped", done, 1);

    // done pin low after last byte: R6
    tgt_done = 1'b0;
    for (int i = 0; i < 4; i++) sent[i] = 8'(8'hA5 ^ i);
    run_load(4, 0, 1'b0);
    chk("R6 err code", err, 3);
    chk("R6 no tail pulses", cap_n, 4 * 8);
    chk("R6 done low", done, 0);
    chk("R9 request high", cfg_n, 1);
    chk("R9 clock low", sclk, 0);
    repeat (10) @(negedge clk);
    chk("R9 err held", err, 3);
    tgt_done = 1'b1;

    // status never asserts: R2
    stat_mode = 1;
    run_load(2, 0, 1'b0);
    chk("R2 err code", err, 1);
    chk("R2 no clock pulses", cap_n, 0);
    chk("R1 hold before check", cfg_low, REQ);
    chk("R9 ready low", in_ready, 0);

    // status never releases: R3 timing
    stat_mode = 2;
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 err cleared by start", err, 0);
    while (!cfg_n || cfg_falls == 0) @(negedge clk);
    begin
      int k = 0;
      while (err == 2'd0 && k < 1000) begin
        @(negedge clk);
        k++;
      end
      chk("R3 timeout cycles", k, TMO);
    end
    chk("R3 err code", err, 2);
    chk("R3 no clock pulses", cap_n, 0);
    chk("R9 busy low", busy, 0);

    // recovery after error: R9
    stat_mode = 0;
    for (int i = 0; i < 3; i++) sent[i] = 8'(8'h81 + i * 16);
    run_load(3, 2, 1'b0);
    chk("R9 err after good load", err, 0);
    chk("R9 done after good load", done, 1);
    chk("R4 bytes after recovery", bytes_ok(3), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule